// File: doc/BRIEF.md
# SD Command Line Sequencer

This block runs the single-wire command line of an SD/MMC host. A request carries a 6-bit command index, a 32-bit argument, a flag that asks for a power-up preamble and a flag that says whether the card will answer. The block sends a 48-bit command frame protected by CRC7. When an answer is expected, it releases the line, waits for the card's start bit and captures a 48-bit short response. It then checks the response CRC, the direction bit and the closing bit.

All line activity advances on a one-cycle bit-rate enable supplied from outside, so a single system clock serves every card clock rate. The sequencer's position is visible at all times as a 4-bit code. A busy flag, a one-cycle completion pulse, the captured index and payload, and two error flags let a controller around it follow each transaction.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset the state code is 0 (idle), busy is 0, the line is released (cmd_oe 0, cmd_out 1) and both error flags and done are 0. Busy is 1 exactly when the state code is nonzero.
- R2: A start pulse is taken only in idle. It moves the state to 1 when init_req is set, and to 2 otherwise. A start pulse in any other state has no effect.
- R3: With init_req set, the line is driven high for 74 bit periods (state 1) before the start bit.
- R4: The command frame is 48 bits, one per bit_en and MSB first, in this order: a 0 start bit (state 2), a 1 direction bit (state 3), the index and then the argument (state 4), the CRC (state 5) and a 1 end bit (state 6). cmd_oe is 1 throughout.
- R5: The frame CRC is CRC7 with generator x^7+x^3+1, initial value 0, taken over the first 40 frame bits.
- R6: After the end bit, with no response expected, the block spends 8 bit periods in state 14 driving the line high and then returns to idle.
- R7: With a response expected, the block enters state 15 with cmd_oe 0. A low cmd_in moves it to state 7. If 64 bit periods pass without a start bit, it sets timeout_err and returns directly to idle.
- R8: The response is taken one bit per bit_en in state order: start bit (7), direction bit (9), 6-bit index (10), 32-bit payload (11), CRC (12) and end bit (13). After the end bit, resp_index and resp_payload hold the received fields and the block spends 8 bit periods in state 14. cmd_oe stays 0 in states 7 to 13 and 15.
- R9: resp_err is set after the response end bit if the received CRC differs from the CRC7 of the first 40 response bits, if the end bit is 0, or if the direction bit is 1. Both error flags clear when the next command is accepted.
- R10: done pulses for exactly one cycle each time the state returns to idle.
- R11: State 8 lasts one clock between the response start bit and the direction bit. bit_en pulses must be at least two clocks apart while a response is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle pulse per card bit period |
| start | input | 1 | Request to issue a command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| init_req | input | 1 | Send the power-up preamble first |
| resp_req | input | 1 | A short response is expected |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Value driven onto the line |
| cmd_oe | output | 1 | Line drive enable |
| state | output | 4 | Sequencer state code |
| busy | output | 1 | State is not idle |
| resp_index | output | 6 | Index field of the last response |
| resp_payload | output | 32 | Payload of the last response |
| resp_err | output | 1 | Response CRC, end bit or direction bit fault |
| timeout_err | output | 1 | No response start bit in time |
| done | output | 1 | One-cycle pulse on return to idle |

## Verification
On every cycle, the assertions check the shape of the state walk. Start is taken only from idle, and counted states move only on a bit_en. State 8 gives way to state 9 after one clock, and the end bit leads only into a wait state. They also check that the line is released while a response is awaited, that done rises only on entry to idle, and that a timeout can only come out of the turnaround wait. The frame contents, the CRC value, the 74, 8 and 64 period lengths, the latched response fields and the three response fault cases can only be shown by the bench's scenarios. In those scenarios, a modelled card answers with intact or deliberately damaged frames.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int INIT_BITS  = 74,
  parameter int TURN_LIMIT = 64,
  parameter int NCC_BITS   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_en,
  input  logic        start,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  input  logic        init_req,
  input  logic        resp_req,
  input  logic        cmd_in,
  output logic        cmd_out,
  output logic        cmd_oe,
  output logic [3:0]  state,
  output logic        busy,
  output logic [5:0]  resp_index,
  output logic [31:0] resp_payload,
  output logic        resp_err,
  output logic        timeout_err,
  output logic        done
);

  localparam int IA_BITS = 38;
  localparam int CRC_W   = 7;
  localparam int CW      = $clog2(INIT_BITS + TURN_LIMIT + NCC_BITS + 64);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_TSTART, S_TDIR, S_TBODY, S_TCRC, S_TEND,
    S_RSTART, S_RIRQ, S_RDIR, S_RIDX, S_RDATA, S_RCRC, S_REND,
    S_RECOV, S_TURN
  } st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [IA_BITS-1:0] sreg;
  logic [CRC_W-1:0]  crc;
  logic [5:0]        idx_sh;
  logic [31:0]       pay_sh;
  logic              rr, crc_bad, dir_bad;

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
    logic f;
    f = b ^ c[6];
    return {c[5:3], c[2] ^ f, c[1:0], f};
  endfunction

  wire last_pre   = cnt == CW'(INIT_BITS - 1);
  wire last_body  = cnt == CW'(IA_BITS - 1);
  wire last_crc   = cnt == CW'(CRC_W - 1);
  wire last_idx   = cnt == CW'(5);
  wire last_data  = cnt == CW'(31);
  wire last_recov = cnt == CW'(NCC_BITS - 1);
  wire last_turn  = cnt == CW'(TURN_LIMIT - 1);

  assign state   = st;
  assign busy    = st != S_IDLE;
  assign cmd_out = (st == S_TSTART) ? 1'b0 :
                   (st == S_TBODY)  ? sreg[IA_BITS-1] :
                   (st == S_TCRC)   ? crc[CRC_W-1] : 1'b1;
  assign cmd_oe  = (st == S_PRE) || (st == S_TSTART) || (st == S_TDIR) ||
                   (st == S_TBODY) || (st == S_TCRC) || (st == S_TEND) ||
                   (st == S_RECOV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      sreg         <= '0;
      crc          <= '0;
      idx_sh       <= '0;
      pay_sh       <= '0;
      rr           <= 1'b0;
      crc_bad      <= 1'b0;
      dir_bad      <= 1'b0;
      resp_index   <= '0;
      resp_payload <= '0;
      resp_err     <= 1'b0;
      timeout_err  <= 1'b0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sreg        <= {cmd_index, cmd_arg};
          rr          <= resp_req;
          crc         <= '0;
          cnt         <= '0;
          crc_bad     <= 1'b0;
          dir_bad     <= 1'b0;
          resp_err    <= 1'b0;
          timeout_err <= 1'b0;
          st          <= init_req ? S_PRE : S_TSTART;
        end
        S_PRE: if (bit_en) begin
          cnt <= last_pre ? '0 : cnt + 1'b1;
          if (last_pre) st <= S_TSTART;
        end
        S_TSTART: if (bit_en) begin
          crc <= crc_step(crc, 1'b0);
          st  <= S_TDIR;
        end
        S_TDIR: if (bit_en) begin
          crc <= crc_step(crc, 1'b1);
          st  <= S_TBODY;
        end
        S_TBODY: if (bit_en) begin
          crc  <= crc_step(crc, sreg[IA_BITS-1]);
          sreg <= {sreg[IA_BITS-2:0], 1'b0};
          cnt  <= last_body ? '0 : cnt + 1'b1;
          if (last_body) st <= S_TCRC;
        end
        S_TCRC: if (bit_en) begin
          crc <= {crc[CRC_W-2:0], 1'b0};
          cnt <= last_crc ? '0 : cnt + 1'b1;
          if (last_crc) st <= S_TEND;
        end
        S_TEND: if (bit_en) begin
          crc <= '0;
          cnt <= '0;
          st  <= rr ? S_TURN : S_RECOV;
        end
        S_TURN: begin
          if (!cmd_in) begin
            cnt <= '0;
            st  <= S_RSTART;
          end else if (bit_en) begin
            cnt <= cnt + 1'b1;
            if (last_turn) begin
              timeout_err <= 1'b1;
              done        <= 1'b1;
              cnt         <= '0;
              st          <= S_IDLE;
            end
          end
        end
        S_RSTART: if (bit_en) begin
          crc <= crc_step(crc, cmd_in);
          st  <= S_RIRQ;
        end
        S_RIRQ: st <= S_RDIR;
        S_RDIR: if (bit_en) begin
          crc     <= crc_step(crc, cmd_in);
          dir_bad <= cmd_in;
          st      <= S_RIDX;
        end
        S_RIDX: if (bit_en) begin
          crc    <= crc_step(crc, cmd_in);
          idx_sh <= {idx_sh[4:0], cmd_in};
          cnt    <= last_idx ? '0 : cnt + 1'b1;
          if (last_idx) st <= S_RDATA;
        end
        S_RDATA: if (bit_en) begin
          crc    <= crc_step(crc, cmd_in);
          pay_sh <= {pay_sh[30:0], cmd_in};
          cnt    <= last_data ? '0 : cnt + 1'b1;
          if (last_data) st <= S_RCRC;
        end
        S_RCRC: if (bit_en) begin
          if (cmd_in != crc[CRC_W-1]) crc_bad <= 1'b1;
          crc <= {crc[CRC_W-2:0], 1'b0};
          cnt <= last_crc ? '0 : cnt + 1'b1;
          if (last_crc) st <= S_REND;
        end
        S_REND: if (bit_en) begin
          resp_err     <= crc_bad | dir_bad | ~cmd_in;
          resp_index   <= idx_sh;
          resp_payload <= pay_sh;
          cnt          <= '0;
          st           <= S_RECOV;
        end
        S_RECOV: if (bit_en) begin
          cnt <= last_recov ? '0 : cnt + 1'b1;
          if (last_recov) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       bit_en,
  input logic [3:0] state,
  input logic       cmd_oe,
  input logic       done,
  input logic       timeout_err
);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd0 && start) |=> (state == 4'd1 || state == 4'd2));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd9, 4'd10,
                    4'd11, 4'd12, 4'd13, 4'd14}) && !bit_en) |=> $stable(state));

  // R11
  irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd8) |=> (state == 4'd9));

  // R6
  end_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd6 && bit_en) |=> (state == 4'd14 || state == 4'd15));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd15 || (state >= 4'd7 && state <= 4'd13)) |-> !cmd_oe);

  // R10
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == 4'd0 && $past(state) != 4'd0));

  // R7
  timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(state) == 4'd15);

endmodule

bind sd_cmd_engine sd_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en), .state(state),
  .cmd_oe(cmd_oe), .done(done), .timeout_err(timeout_err)
);

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        init_req = 1'b0;
  logic        resp_req = 1'b0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe, busy, resp_err, timeout_err, done;
  logic [3:0]  state;
  logic [5:0]  resp_index;
  logic [31:0] resp_payload;

  sd_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .init_req(init_req),
    .resp_req(resp_req), .cmd_in(cmd_in), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .state(state), .busy(busy), .resp_index(resp_index),
    .resp_payload(resp_payload), .resp_err(resp_err),
    .timeout_err(timeout_err), .done(done)
  );

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  int ph = 0;
  logic [47:0] txf;
  int txn, nin, nncc, nwait, n8, viol, ndone;

  // fields: [42:37] index, [36:5] argument, [4] init, [3] response, [2:0] mode
  // mode 0 clean, 1 bad CRC, 2 end bit 0, 3 direction bit 1, 4 silent card
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {6'd0,  32'h00000000, 1'b1, 1'b1, 3'd0},
    {6'd8,  32'h000001AA, 1'b0, 1'b1, 3'd0},
    {6'd17, 32'h12345678, 1'b0, 1'b1, 3'd1},
    {6'd55, 32'hFFFFFFFF, 1'b0, 1'b1, 3'd2},
    {6'd63, 32'hA5A55A5A, 1'b0, 1'b1, 3'd3},
    {6'd2,  32'hDEADBEEF, 1'b0, 1'b1, 3'd4},
    {6'd7,  32'h0F0F0F0F, 1'b0, 1'b0, 3'd0},
    {6'd41, 32'h80000001, 1'b1, 1'b0, 3'd0}
  };

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] r = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb;
      fb = d[i] ^ r[6];
      r = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // bit-rate enable driver and line monitor
  initial begin
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      bit_en = (ph == 0);
      if (done) ndone++;
      if (state == 4'd8) n8++;
      if ((state == 4'd15 || (state >= 4'd7 && state <= 4'd13)) && cmd_oe) viol++;
      if (ph == 0) begin
        if (state >= 4'd2 && state <= 4'd6) begin
          txf = {txf[46:0], cmd_out};
          txn++;
          if (!cmd_oe) viol++;
        end
        if (state == 4'd1) begin
          nin++;
          if (!cmd_oe || !cmd_out) viol++;
        end
        if (state == 4'd14) begin
          nncc++;
          if (!cmd_oe || !cmd_out) viol++;
        end
        if (state == 4'd15) nwait++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_pulse();
    do tick(); while (ph != 0);
  endtask

  task automatic clear_counts();
    txf = '0; txn = 0; nin = 0; nncc = 0; nwait = 0; n8 = 0; viol = 0; ndone = 0;
  endtask

  task automatic run_cmd(input logic [5:0] ix, input logic [31:0] ag, input bit ini,
                         input bit rsp, input int mode, input int dly);
    logic [47:0] rf;
    logic [39:0] rh;
    clear_counts();
    cmd_index = ix; cmd_arg = ag; init_req = ini; resp_req = rsp;
    start = 1'b1;
    tick();
    start = 1'b0;
    if (rsp && mode != 4) begin
      rh = {1'b0, (mode == 3) ? 1'b1 : 1'b0, ix, ~ag};
      rf = {rh, crc7(rh) ^ ((mode == 1) ? 7'h01 : 7'h00), (mode == 2) ? 1'b0 : 1'b1};
      while (state != 4'd15) tick();
      repeat (dly) wait_pulse();
      cmd_in = rf[47];
      for (int b = 46; b >= 0; b--) begin
        wait_pulse();
        cmd_in = rf[b];
      end
      wait_pulse();
      cmd_in = 1'b1;
    end
    while (state != 4'd0) tick();
  endtask

  initial begin
    clear_counts();
    repeat (3) tick();
    // R1: reset state
    chk(state == 4'd0 && !busy, "R1 reset idle", {busy, state}, 0);
    chk(!cmd_oe && cmd_out, "R1 reset line released", {cmd_oe, cmd_out}, 1);
    chk(!resp_err && !timeout_err && !done, "R1 reset flags", {resp_err, timeout_err, done}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(state == 4'd0, "R2 no start stays idle", state, 0);

    for (int v = 0; v < NV; v++) begin
      logic [5:0]  ix;
      logic [31:0] ag;
      logic        ini, rsp;
      int          mode;
      logic [39:0] hd;
      ix = VEC[v][42:37]; ag = VEC[v][36:5]; ini = VEC[v][4]; rsp = VEC[v][3];
      mode = int'(VEC[v][2:0]);
      hd = {1'b0, 1'b1, ix, ag};
      run_cmd(ix, ag, ini, rsp, mode, 2 + 7 * v);
      // R10 completion pulse sampled in the first idle cycle
      chk(done && !busy, "R10 done on idle", {done, busy}, 2);
      // R4 R5 frame content
      chk(txn == 48 && txf == {hd, crc7(hd), 1'b1}, "R4 R5 command frame", txf, {hd, crc7(hd), 1'b1});
      // R3 preamble length
      chk(nin == (ini ? 74 : 0), "R3 preamble periods", nin, ini ? 74 : 0);
      // R6 recovery length
      chk(nncc == ((mode == 4 && rsp) ? 0 : 8), "R6 recovery periods", nncc, (mode == 4 && rsp) ? 0 : 8);
      chk(viol == 0, "R8 line drive per state", viol, 0);
      // R7 R9 error flags, cleared by each new command
      chk(timeout_err == (rsp && mode == 4), "R7 timeout flag", timeout_err, rsp && mode == 4);
      chk(resp_err == (rsp && mode >= 1 && mode <= 3), "R9 response error flag", resp_err,
          rsp && mode >= 1 && mode <= 3);
      if (rsp && mode == 4)
        chk(nwait == 64, "R7 turnaround limit", nwait, 64);
      if (rsp && mode != 4) begin
        chk(resp_index == ix, "R8 response index", resp_index, ix);
        chk(resp_payload == ~ag, "R8 response payload", resp_payload, ~ag);
        chk(n8 == 1, "R11 state 8 one clock", n8, 1);
      end
      repeat (3) tick();
      chk(ndone == 1, "R10 single done pulse", ndone, 1);
    end

    // R2: start during recovery is ignored
    clear_counts();
    cmd_index = 6'd12; cmd_arg = 32'h0; init_req = 1'b0; resp_req = 1'b0;
    start = 1'b1;
    tick();
    start = 1'b0;
    while (state != 4'd14) tick();
    init_req = 1'b1;
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(state == 4'd14, "R2 start ignored while busy", state, 14);
    while (state != 4'd0) tick();
    repeat (20) tick();
    chk(state == 4'd0 && !busy && ndone == 1 && txn == 48 && nin == 0,
        "R2 no second command", {state, ndone}, 1);

    // R1: busy follows a nonzero state during a command
    clear_counts();
    cmd_index = 6'd5; init_req = 1'b0; resp_req = 1'b0;
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(busy && state == 4'd2, "R1 busy with start-bit state", {busy, state}, {1'b1, 4'd2});
    while (state != 4'd0) tick();
    chk(!busy, "R1 busy clear in idle", busy, 0);

    summary();
  end

endmodule